// File: doc/BRIEF.md
# Reconfigurable Test Register (Flip-Flop / Scan / Pattern Generator / Signature Compactor)

This block is an N-bit register bank meant to sit at the boundary of a logic block in place of ordinary flip-flops. A 2-bit mode input selects one of four behaviours at run time. It can act as plain parallel-load flip-flops or as a serial scan chain. It can also run as an autonomous linear feedback shift register that produces pseudo-random stimulus, or as a multiple-input signature register that folds a parallel response word into its state on every clock. The pattern generator and the compactor use one shared feedback network. That network has the external-XOR (standard) form, and its tap set is a parameter.

The usual flow has four steps. Shift or load a seed. Switch to generator mode to drive stimulus, or switch a second instance to compactor mode to absorb the responses. After the last response, compare the held content against the known-good signature. The compare result is given by a combinational match output that tests the register against a GOLDEN parameter. A synchronous reset clears the register. A separate seed-load strobe forces the SEED parameter into the register whatever the mode.

The mode acts as the state of the controlling machine. It has four named states: SCAN (00), GEN (01), COMP (10) and LOAD (11). Every transition between any two of them is allowed and takes effect at the next clock edge. The register content is carried across the transition unchanged.

Top module: `bilbo_reg`

## Requirements
- R1: While `rst` is high at a rising clock edge, the register clears to all zeros. Reset has priority over `seed_ld` and over every mode.
- R2: When `seed_ld` is high at a clock edge without reset, the register takes the SEED parameter, whatever the mode.
- R3: In LOAD mode (`mode` = 2'b11), each clock edge copies `d_in` into the register, so `q` equals the `d_in` of the previous edge.
- R4: In SCAN mode (`mode` = 2'b00), each edge shifts the register one place toward bit 0. `scan_in` enters bit N-1, and `scan_out` always shows bit 0.
- R5: In GEN mode (`mode` = 2'b01), bit i takes bit i+1 for i < N-1. Bit N-1 takes the XOR of bit 0 with every bit i (1 ≤ i ≤ N-1) whose TAPS bit i is 1. With N=3 and taps for 1 + x + x^3, starting from `q` = 3'b001, the `q` sequence is 4, 2, 5, 6, 7, 3, then 1 again.
- R6: With a primitive tap set, GEN mode visits all 2^N − 1 nonzero states, each exactly once, before it returns to the starting state.
- R7: In GEN mode a register holding all zeros stays at all zeros (lock-up). A nonzero register never becomes zero.
- R8: In COMP mode (`mode` = 2'b10), the next state is the GEN-mode next state XORed bitwise with `d_in`. Starting from zero, the signature of the bitwise XOR of two response streams equals the XOR of their separate signatures.
- R9: `sig_match` is high in the same cycle the register equals GOLDEN, and low otherwise.
- R10: A change of `mode` has no effect until the next clock edge. The content at that edge is the starting point of the new mode, so a seed shifted in by scan is the first state that GEN mode advances from.
- R11: The x^0 term is always present. TAPS bit 0 is ignored, so a tap set with bit 0 cleared gives the same sequence as one with it set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high, clears the register |
| mode | input | 2 | 00 SCAN, 01 GEN, 10 COMP, 11 LOAD |
| seed_ld | input | 1 | Loads the SEED parameter at the next edge |
| d_in | input | N | Parallel data (LOAD) or response word (COMP) |
| q | output | N | Register content |
| scan_in | input | 1 | Serial input into bit N-1 in SCAN mode |
| scan_out | output | 1 | Serial output, bit 0 of the register |
| sig_match | output | 1 | High when the register equals GOLDEN |

## Verification
The bench builds two instances. The first is an 8-bit register with taps for x^8 + x^6 + x^5 + x^4 + 1, SEED 8'h01 and GOLDEN 8'hA5. Its 255-state cycle is short enough to walk in full, which checks the maximal period and the absence of repeats. The second is a 3-bit register whose TAPS have bit 0 cleared for 1 + x + x^3, with SEED 3'b001 and GOLDEN 3'd7. It makes the exact seven-state order comparable to the required sequence, and it shows that the implied x^0 tap needs no parameter bit. Compaction is checked against a model of the matrix equation and by superposing two response streams.

// File: rtl/bilbo_pkg.sv
package bilbo_pkg;

    // Operating modes of the register; the code values are the mode pin encoding.
    typedef enum logic [1:0] {
        MODE_SCAN = 2'b00,
        MODE_GEN  = 2'b01,
        MODE_COMP = 2'b10,
        MODE_LOAD = 2'b11
    } bilbo_mode_e;

endpackage

// File: rtl/bilbo_fb_net.sv
// Standard (external-XOR) LFSR step: shift toward bit 0, feedback into bit N-1.
module bilbo_fb_net #(
    parameter int          N    = 8,
    parameter logic [N-1:0] TAPS = 8'b0111_0001
) (
    input  logic [N-1:0] cur,
    output logic [N-1:0] stepped
);
    // The constant term of the polynomial is always present.
    localparam logic [N-1:0] TAP_MASK = TAPS | {{(N-1){1'b0}}, 1'b1};

    genvar i;
    generate
        for (i = 0; i < N - 1; i++) begin : g_shift
            assign stepped[i] = cur[i+1];
        end
    endgenerate

    assign stepped[N-1] = ^(cur & TAP_MASK);

endmodule

// File: rtl/bilbo_next_sel.sv
// Chooses the next register value from the current mode.
module bilbo_next_sel
    import bilbo_pkg::*;
#(
    parameter int N = 8
) (
    input  bilbo_mode_e  mode,
    input  logic [N-1:0] cur,
    input  logic [N-1:0] stepped,
    input  logic [N-1:0] d_in,
    input  logic         scan_in,
    output logic [N-1:0] nxt
);
    always_comb begin
        unique case (mode)
            MODE_SCAN: nxt = {scan_in, cur[N-1:1]};
            MODE_GEN:  nxt = stepped;
            MODE_COMP: nxt = stepped ^ d_in;
            MODE_LOAD: nxt = d_in;
        endcase
    end

endmodule

// File: rtl/bilbo_sig_cmp.sv
// Compares the held value against the known-good signature.
module bilbo_sig_cmp #(
    parameter int           N      = 8,
    parameter logic [N-1:0] GOLDEN = '0
) (
    input  logic [N-1:0] sig,
    output logic         match
);
    assign match = (sig == GOLDEN);

endmodule

// File: rtl/bilbo_reg.sv
module bilbo_reg
    import bilbo_pkg::*;
#(
    parameter int           N      = 8,
    parameter logic [N-1:0] TAPS   = 8'b0111_0001,
    parameter logic [N-1:0] SEED   = 8'h01,
    parameter logic [N-1:0] GOLDEN = 8'hA5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [1:0]   mode,
    input  logic         seed_ld,
    input  logic [N-1:0] d_in,
    output logic [N-1:0] q,
    input  logic         scan_in,
    output logic         scan_out,
    output logic         sig_match
);
    bilbo_mode_e  cur_mode;
    logic [N-1:0] state_q;
    logic [N-1:0] stepped;
    logic [N-1:0] next_state;

    assign cur_mode = bilbo_mode_e'(mode);

    bilbo_fb_net #(.N(N), .TAPS(TAPS)) u_fb (
        .cur     (state_q),
        .stepped (stepped)
    );

    bilbo_next_sel #(.N(N)) u_sel (
        .mode    (cur_mode),
        .cur     (state_q),
        .stepped (stepped),
        .d_in    (d_in),
        .scan_in (scan_in),
        .nxt     (next_state)
    );

    // State register: reset, then seed strobe, then the mode's next value.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else if (seed_ld) begin
            state_q <= SEED;
        end else begin
            state_q <= next_state;
        end
    end

    // Output process.
    always_comb begin
        q        = state_q;
        scan_out = state_q[0];
    end

    bilbo_sig_cmp #(.N(N), .GOLDEN(GOLDEN)) u_cmp (
        .sig   (state_q),
        .match (sig_match)
    );

endmodule

// File: rtl/bilbo_reg_chk.sv
module bilbo_reg_chk #(
    parameter int           N    = 8,
    parameter logic [N-1:0] SEED = '0
) (
    input logic         clk,
    input logic         rst,
    input logic [1:0]   mode,
    input logic         seed_ld,
    input logic [N-1:0] d_in,
    input logic         scan_in,
    input logic [N-1:0] q
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> (q == '0));

    // R2
    seed_load_chk: assert property (@(posedge clk) disable iff (rst)
        seed_ld |=> (q == SEED));

    // R3
    par_load_chk: assert property (@(posedge clk) disable iff (rst)
        (!seed_ld && mode == 2'b11) |=> (q == $past(d_in)));

    // R4
    scan_shift_chk: assert property (@(posedge clk) disable iff (rst)
        (!seed_ld && mode == 2'b00) |=> (q == {$past(scan_in), $past(q[N-1:1])}));

    // R7
    gen_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        (!seed_ld && mode == 2'b01 && q != '0) |=> (q != '0));

    // R7
    gen_lockup_chk: assert property (@(posedge clk) disable iff (rst)
        (!seed_ld && mode == 2'b01 && q == '0) |=> (q == '0));

    // R8
    comp_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!seed_ld && mode == 2'b10 && q == '0 && d_in == '0) |=> (q == '0));

endmodule

bind bilbo_reg bilbo_reg_chk #(.N(N), .SEED(SEED)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .mode    (mode),
    .seed_ld (seed_ld),
    .d_in    (d_in),
    .scan_in (scan_in),
    .q       (q)
);

// File: tb/tb_bilbo_reg.sv
module tb_bilbo_reg;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] mode;
    logic       seed_ld;
    logic [7:0] d_in;
    logic       scan_in;
    logic [7:0] q;
    logic       scan_out;
    logic       sig_match;

    logic [1:0] mode3;
    logic       seed3;
    logic [2:0] q3;
    logic       so3;
    logic       match3;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bilbo_reg #(.N(8), .TAPS(8'b0111_0001), .SEED(8'h01), .GOLDEN(8'hA5)) dut (
        .clk(clk), .rst(rst), .mode(mode), .seed_ld(seed_ld), .d_in(d_in),
        .q(q), .scan_in(scan_in), .scan_out(scan_out), .sig_match(sig_match)
    );

    // Taps for 1 + x + x^3 with bit 0 deliberately cleared (R11).
    bilbo_reg #(.N(3), .TAPS(3'b010), .SEED(3'b001), .GOLDEN(3'd7)) dut3 (
        .clk(clk), .rst(rst), .mode(mode3), .seed_ld(seed3), .d_in(3'b000),
        .q(q3), .scan_in(1'b0), .scan_out(so3), .sig_match(match3)
    );

    // Reference step from R5 for taps x^8 + x^6 + x^5 + x^4 + 1.
    function automatic logic [7:0] ref_step(input logic [7:0] s);
        return {s[0] ^ s[4] ^ s[5] ^ s[6], s[7:1]};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        rst = 1'b1; mode = 2'b11; d_in = 8'hFF; seed_ld = 1'b1; scan_in = 1'b1;
        mode3 = 2'b01; seed3 = 1'b1;
        tick(); tick();
        chk("R1", "q after reset", q, 8'h00);
        chk("R1", "q3 after reset", q3, 3'b000);
        chk("R1", "scan_out after reset", scan_out, 1'b0);
        chk("R9", "no match at zero", sig_match, 1'b0);
        rst = 1'b0; seed_ld = 1'b0; seed3 = 1'b0; mode3 = 2'b11;
    endtask

    task automatic t_load();
        mode = 2'b11; d_in = 8'hA5;
        tick();
        chk("R3", "parallel load", q, 8'hA5);
        chk("R9", "match on golden", sig_match, 1'b1);
        d_in = 8'hA4;
        chk("R10", "held before edge", q, 8'hA5);
        tick();
        chk("R3", "parallel load 2", q, 8'hA4);
        chk("R9", "no match off golden", sig_match, 1'b0);
    endtask

    task automatic t_seed();
        mode = 2'b11; d_in = 8'h00; seed_ld = 1'b1;
        tick();
        chk("R2", "seed over load", q, 8'h01);
        seed_ld = 1'b0;
    endtask

    task automatic t_scan();
        logic [7:0] bits = 8'b0100_1101;
        logic [7:0] m = 8'h01;
        int bad = 0;
        mode = 2'b00;
        for (int i = 0; i < 8; i++) begin
            scan_in = bits[i];
            tick();
            m = {bits[i], m[7:1]};
            if (q !== m || scan_out !== m[0]) bad++;
        end
        chk("R4", "scan steps mismatching", bad, 0);
        chk("R4", "scanned word", q, bits);
        chk("R4", "scan_out bit0", scan_out, bits[0]);
    endtask

    task automatic t_seq3();
        logic [2:0] exp_seq [7] = '{3'd4, 3'd2, 3'd5, 3'd6, 3'd7, 3'd3, 3'd1};
        seed3 = 1'b1;
        tick();
        seed3 = 1'b0; mode3 = 2'b01;
        chk("R2", "small seed", q3, 3'd1);
        for (int i = 0; i < 7; i++) begin
            tick();
            chk("R5", "3-bit order (R11 tap bit0 clear)", q3, exp_seq[i]);
            chk("R9", "small match", match3, exp_seq[i] == 3'd7);
        end
        mode3 = 2'b11;
    endtask

    task automatic t_period();
        logic [255:0] seen = '0;
        int bad = 0;
        int dup = 0;
        logic [7:0] m;
        seed_ld = 1'b1;
        tick();
        seed_ld = 1'b0; mode = 2'b01;
        m = q;
        seen[m] = 1'b1;
        for (int i = 1; i < 255; i++) begin
            tick();
            m = ref_step(m);
            if (q !== m) bad++;
            if (q == 8'h00 || seen[q]) dup++;
            seen[q] = 1'b1;
        end
        chk("R5", "8-bit steps vs model", bad, 0);
        chk("R6", "zero or repeated states", dup, 0);
        tick();
        chk("R6", "returns to seed after 255", q, 8'h01);
    endtask

    task automatic t_lock();
        mode = 2'b11; d_in = 8'h00;
        tick();
        mode = 2'b01;
        tick(); tick(); tick();
        chk("R7", "zero lock-up", q, 8'h00);
    endtask

    task automatic run_comp(input logic [7:0] w [6], output logic [7:0] sig);
        mode = 2'b11; d_in = 8'h00;
        tick();
        mode = 2'b10;
        for (int i = 0; i < 6; i++) begin
            d_in = w[i];
            tick();
        end
        sig = q;
        mode = 2'b11;
    endtask

    task automatic t_comp();
        logic [7:0] a [6] = '{8'h3C, 8'hF0, 8'h11, 8'h80, 8'h07, 8'hAA};
        logic [7:0] b [6] = '{8'h5A, 8'h01, 8'hC3, 8'h7E, 8'h90, 8'h24};
        logic [7:0] ab [6];
        logic [7:0] sa, sb, sab, m;
        m = 8'h00;
        for (int i = 0; i < 6; i++) begin
            m = ref_step(m) ^ a[i];
            ab[i] = a[i] ^ b[i];
        end
        run_comp(a, sa);
        chk("R8", "signature A", sa, m);
        run_comp(b, sb);
        run_comp(ab, sab);
        chk("R8", "superposition", sab, sa ^ sb);
    endtask

    task automatic t_switch();
        logic [7:0] w = 8'h9C;
        mode = 2'b00;
        for (int i = 0; i < 8; i++) begin
            scan_in = w[i];
            tick();
        end
        mode = 2'b01;
        chk("R10", "seed held at mode change", q, 8'h9C);
        tick();
        chk("R10", "gen starts from scanned seed", q, ref_step(8'h9C));
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_load();
        t_seed();
        t_scan();
        t_seq3();
        t_period();
        t_lock();
        t_comp();
        t_switch();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule